// File: doc/BRIEF.md
# Serial Snapshot Streaming Transmitter

This block captures a snapshot of up to sixteen signed 24-bit measurement samples and streams them to an external receiver over three lines: a word-select line, a data line and a serial clock that the block generates itself. On an accepted start strobe every sample and its availability flag are frozen. Each selected sample is widened to 32 bits by sign extension and sent most significant bit first. A one-cycle done pulse marks the end of the burst.

An 8-bit configuration input sets the serial clock rate, the package size, an optional pause between packages, the subset of words sent and the polarity of the select line. The configuration is registered every cycle and copied into a burst-private copy when a burst starts, so changes during a burst take effect only on the next one. A per-word availability mask replaces missing measurements with all-zero words, which keeps the word count and the word order the same on reduced builds. An enable input gates the whole block.

Top module: `snap_stream_tx`

## Requirements
- R1: During reset and after reset, with no burst running, the data line and the serial clock are high and done is low. The configuration register resets to 0, so the select line is high.
- R2: The word-subset field is cfg_in[4:3]. With 00 or 11, all sixteen words go out in index order 0..15. With 01, only words 0..6 go out. With 10, only words 7..15 go out, in index order.
- R3: Sample k is taken from samples_flat[24k+23:24k]. It is sign-extended to 32 bits and sent most significant bit first.
- R4: A word whose avail_mask bit is 0 is sent as 32 zero bits. The number and order of the words do not change.
- R5: cfg_in[0]=0 gives a bit period of 2 system cycles and 1 gives 4. The serial clock is low in the first half of each bit period and high in the second half. The data line changes only when the clock falls, so it is stable when the clock rises. The clock idles high.
- R6: With cfg_in[2]=1, each package except the last is followed by a gap of exactly 7 bit periods. During the gap the select line is inactive and the clock stays high. With cfg_in[2]=0, the burst streams without a break.
- R7: cfg_in[1] sets the package length when gaps are on: 0 gives 32 bits and 1 gives 8 bits. With gaps off it has no visible effect.
- R8: cfg_in[5] is the active select level while bits are shifted. The select line takes the opposite level in gaps and when idle.
- R9: cfg_in[7:6] has no effect on the output stream.
- R10: A start strobe during a burst is ignored. The configuration is sampled once at the accepted start and stays fixed for the whole burst.
- R11: With enable low, start is ignored. Dropping enable during a burst returns all lines to idle on the next cycle, and no done pulse follows.
- R12: done is high for exactly one cycle, in the cycle after the final bit period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice or four times the serial rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and blocks bursts |
| start | input | 1 | Start strobe, accepted only when idle and enabled |
| cfg_in | input | 8 | Configuration: rate, package size, gap, subset, select polarity |
| avail_mask | input | 16 | Per-word availability; 0 forces a zero word |
| samples_flat | input | 384 | Sixteen 24-bit signed samples, word k at bits 24k+23:24k |
| ser_clk | output | 1 | Generated serial clock, idles high |
| ser_data | output | 1 | Serial data, changes on falling clock edges |
| ser_sel | output | 1 | Word-select line, polarity set by configuration |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench decodes the stream only at rising serial-clock edges, as a receiver would. A design that changed data on the wrong edge, skipped sign extension or used the wrong word offset for the power subset would deliver wrong words. Gap lengths and the number of gaps are counted for both package sizes and both clock rates. This exposes an off-by-one gap counter, a gap placed after the final package, or 8-bit packaging that leaks into the no-gap mode. The bench disturbs a burst with a second start and a reconfiguration, and it drops enable mid-burst. A design that restarted, changed clock rate or polarity in flight, or still emitted done would show a corrupted stream or a stray pulse.

// File: rtl/snap_stream_pkg.sv
// Shared types and helpers for the snapshot streaming transmitter.
// Assumes the 8-bit configuration layout given in the block brief.
package snap_stream_pkg;

    localparam int CFG_W = 8;

    // Engine states: idle, shifting a package, pausing between packages.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_t;

    // Decoded configuration fields.
    typedef struct packed {
        logic       sel_pol;   // active select level
        logic [1:0] subset;    // word subset, reserved code folded to 00
        logic       gap_en;    // pause between packages
        logic       pkg_small; // short packages when gaps are on
        logic       clk_slow;  // slower serial clock
    } snap_cfg_t;

    // Map a raw configuration byte to its fields; upper two bits are ignored.
    function automatic snap_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        snap_cfg_t c;
        c.clk_slow  = raw[0];
        c.pkg_small = raw[1];
        c.gap_en    = raw[2];
        c.subset    = (raw[4:3] == 2'b11) ? 2'b00 : raw[4:3];
        c.sel_pol   = raw[5];
        return c;
    endfunction

endpackage

// File: rtl/snap_cfg_reg.sv
// Configuration register: captures the raw configuration byte every cycle
// and holds it in decoded form. Assumes the byte is quasi-static.
module snap_cfg_reg
    import snap_stream_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_raw,
    output snap_cfg_t        cfg_q
);

    // Register the decoded configuration; all fields reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= decode_cfg(cfg_raw);
        end
    end

endmodule

// File: rtl/snap_word_src.sv
// Snapshot store and word selector. On capture it freezes every sample
// and its availability flag. It presents the sign-extended (or zeroed)
// word at the requested index. Assumes word_idx < NUM_WORDS.
module snap_word_src #(
    parameter int NUM_WORDS = 16,
    parameter int SAMPLE_W  = 24,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int EXT_W    = WORD_W - SAMPLE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture,
    input  logic [NUM_WORDS*SAMPLE_W-1:0] samples_flat,
    input  logic [NUM_WORDS-1:0]          avail_mask,
    input  logic [IDX_W-1:0]              word_idx,
    output logic [WORD_W-1:0]             word_out
);

    logic [WORD_W-1:0] ext_word [NUM_WORDS];

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
        logic [SAMPLE_W-1:0] raw_q;
        logic                av_q;

        // Freeze this sample and its availability flag at burst start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q <= '0;
                av_q  <= 1'b0;
            end else if (capture) begin
                raw_q <= samples_flat[k*SAMPLE_W +: SAMPLE_W];
                av_q  <= avail_mask[k];
            end
        end

        assign ext_word[k] = av_q ? {{EXT_W{raw_q[SAMPLE_W-1]}}, raw_q}
                                  : '0;
    end

    // Select the word currently being shifted.
    always_comb begin
        word_out = ext_word[word_idx];
    end

endmodule

// File: rtl/snap_bit_timer.sv
// Bit-period timer. While run is high it counts system cycles within a
// serial bit period of DIV_FAST or DIV_SLOW cycles. It flags the low
// half of the period and the period's last cycle. Assumes even dividers.
module snap_bit_timer #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4,
    localparam int CNT_W   = $clog2(DIV_SLOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic low_phase,
    output logic period_end
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] half_val;

    // Pick the terminal count and the half point for the selected rate.
    always_comb begin
        last_val = slow ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
        half_val = slow ? CNT_W'(DIV_SLOW / 2) : CNT_W'(DIV_FAST / 2);
    end

    // Count cycles within a bit period; park at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == last_val) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign low_phase  = run && (cnt < half_val);
    assign period_end = run && (cnt == last_val);

endmodule

// File: rtl/snap_bit_engine.sv
// Burst sequencer. It accepts a start when idle and enabled, latches the
// configuration, and walks the chosen word subset bit by bit, inserting
// gaps when asked. It drives the three serial lines and the done pulse.
// Assumes the word source answers word_idx within the same cycle.
module snap_bit_engine
    import snap_stream_pkg::*;
#(
    parameter int NUM_WORDS   = 16,
    parameter int GROUP_A     = 7,
    parameter int WORD_W      = 32,
    parameter int PKG_SMALL   = 8,
    parameter int GAP_PERIODS = 7,
    localparam int IDX_W      = $clog2(NUM_WORDS),
    localparam int SLOT_W     = $clog2(NUM_WORDS + 1),
    localparam int BIT_W      = $clog2(WORD_W),
    localparam int PKG_LOG    = $clog2(PKG_SMALL),
    localparam int GAP_W      = $clog2(GAP_PERIODS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  snap_cfg_t         cfg_live,
    input  logic              period_end,
    input  logic              low_phase,
    input  logic [WORD_W-1:0] cur_word,
    output logic              capture,
    output logic              run,
    output snap_cfg_t         cfg_b,
    output logic [IDX_W-1:0]  word_idx,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_sel,
    output logic              done
);

    eng_state_t         state;
    logic [SLOT_W-1:0]  slot;
    logic [SLOT_W-1:0]  first_b;
    logic [SLOT_W-1:0]  count_b;
    logic [SLOT_W-1:0]  first_n;
    logic [SLOT_W-1:0]  count_n;
    logic [BIT_W-1:0]   bitpos;
    logic [GAP_W-1:0]   gapcnt;
    logic               done_q;
    logic               word_last;
    logic               slot_last;
    logic               pkg_end;

    // Translate the subset code into a first index and a word count.
    always_comb begin
        case (cfg_live.subset)
            2'b01: begin
                first_n = '0;
                count_n = SLOT_W'(GROUP_A);
            end
            2'b10: begin
                first_n = SLOT_W'(GROUP_A);
                count_n = SLOT_W'(NUM_WORDS - GROUP_A);
            end
            default: begin
                first_n = '0;
                count_n = SLOT_W'(NUM_WORDS);
            end
        endcase
    end

    // Position flags for the bit now on the line.
    always_comb begin
        word_last = (bitpos == BIT_W'(WORD_W - 1));
        slot_last = (slot == count_b - 1'b1);
        if (!cfg_b.gap_en) begin
            pkg_end = 1'b0;
        end else if (cfg_b.pkg_small) begin
            pkg_end = (bitpos[PKG_LOG-1:0] == {PKG_LOG{1'b1}});
        end else begin
            pkg_end = word_last;
        end
    end

    // Sequence the burst: accept, shift, pause, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            slot    <= '0;
            first_b <= '0;
            count_b <= '0;
            bitpos  <= '0;
            gapcnt  <= '0;
            cfg_b   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start) begin
                            state   <= ST_SHIFT;
                            cfg_b   <= cfg_live;
                            first_b <= first_n;
                            count_b <= count_n;
                            slot    <= '0;
                            bitpos  <= '0;
                            gapcnt  <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        if (period_end) begin
                            if (word_last && slot_last) begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                bitpos <= word_last ? '0 : bitpos + 1'b1;
                                if (word_last) begin
                                    slot <= slot + 1'b1;
                                end
                                if (pkg_end) begin
                                    state  <= ST_GAP;
                                    gapcnt <= '0;
                                end
                            end
                        end
                    end
                    ST_GAP: begin
                        if (period_end) begin
                            if (gapcnt == GAP_W'(GAP_PERIODS - 1)) begin
                                state <= ST_SHIFT;
                            end else begin
                                gapcnt <= gapcnt + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign capture  = (state == ST_IDLE) && enable && start;
    assign run      = (state != ST_IDLE);
    assign word_idx = IDX_W'(first_b + slot);
    assign done     = done_q;

    // Drive the serial lines from the engine state.
    always_comb begin
        ser_clk  = !((state == ST_SHIFT) && low_phase);
        ser_data = (state == ST_SHIFT) ? cur_word[BIT_W'(WORD_W - 1) - bitpos]
                                       : 1'b1;
        case (state)
            ST_SHIFT: ser_sel = cfg_b.sel_pol;
            ST_GAP:   ser_sel = !cfg_b.sel_pol;
            default:  ser_sel = !cfg_live.sel_pol;
        endcase
    end

endmodule

// File: rtl/snap_stream_tx.sv
// Top of the snapshot streaming transmitter. It connects the configuration
// register, snapshot store, bit timer and burst sequencer. Assumes clk
// runs at the fast divider ratio times the nominal fast serial rate.
module snap_stream_tx
    import snap_stream_pkg::*;
#(
    parameter int NUM_WORDS   = 16,
    parameter int GROUP_A     = 7,
    parameter int SAMPLE_W    = 24,
    parameter int WORD_W      = 32,
    parameter int PKG_SMALL   = 8,
    parameter int GAP_PERIODS = 7,
    parameter int DIV_FAST    = 2,
    parameter int DIV_SLOW    = 4,
    localparam int IDX_W      = $clog2(NUM_WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          start,
    input  logic [CFG_W-1:0]              cfg_in,
    input  logic [NUM_WORDS-1:0]          avail_mask,
    input  logic [NUM_WORDS*SAMPLE_W-1:0] samples_flat,
    output logic                          ser_clk,
    output logic                          ser_data,
    output logic                          ser_sel,
    output logic                          done
);

    snap_cfg_t         cfg_live;
    snap_cfg_t         burst_cfg;
    logic              capture;
    logic              eng_busy;
    logic              low_phase;
    logic              period_end;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] cur_word;

    snap_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_raw (cfg_in),
        .cfg_q   (cfg_live)
    );

    snap_word_src #(
        .NUM_WORDS (NUM_WORDS),
        .SAMPLE_W  (SAMPLE_W),
        .WORD_W    (WORD_W)
    ) u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .samples_flat (samples_flat),
        .avail_mask   (avail_mask),
        .word_idx     (word_idx),
        .word_out     (cur_word)
    );

    snap_bit_timer #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (eng_busy),
        .slow       (burst_cfg.clk_slow),
        .low_phase  (low_phase),
        .period_end (period_end)
    );

    snap_bit_engine #(
        .NUM_WORDS   (NUM_WORDS),
        .GROUP_A     (GROUP_A),
        .WORD_W      (WORD_W),
        .PKG_SMALL   (PKG_SMALL),
        .GAP_PERIODS (GAP_PERIODS)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start      (start),
        .cfg_live   (cfg_live),
        .period_end (period_end),
        .low_phase  (low_phase),
        .cur_word   (cur_word),
        .capture    (capture),
        .run        (eng_busy),
        .cfg_b      (burst_cfg),
        .word_idx   (word_idx),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_sel    (ser_sel),
        .done       (done)
    );

endmodule

// File: rtl/snap_stream_chk.sv
// Protocol checker for the snapshot streaming transmitter, bound to the top.
// Assumes the bound signals are the engine's busy flag and burst config.
module snap_stream_chk
    import snap_stream_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      enable,
    input logic      ser_clk,
    input logic      ser_data,
    input logic      ser_sel,
    input logic      done,
    input logic      busy,
    input snap_cfg_t cfg_b
);

    // Idle lines sit high when no burst runs.
    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ser_data && ser_clk));

    // Data must not move on a rising serial clock.
    assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));

    // Clock only toggles low while select is active.
    assert_sel_active_when_clocking_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |-> (ser_sel == cfg_b.sel_pol));

    // Burst configuration frozen while a burst continues.
    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_b));

    // No done pulse after the block is disabled.
    assert_abort_no_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done);

    // Done lasts one cycle and follows a running burst.
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_burst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

bind snap_stream_tx snap_stream_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_sel  (ser_sel),
    .done     (done),
    .busy     (eng_busy),
    .cfg_b    (burst_cfg)
);

// File: tb/snap_stream_tx_tb.sv
// Self-checking bench: a vector table of configurations walked by one loop,
// then directed tests for reset, restart immunity and enable handling.
module snap_stream_tx_tb_top;

    localparam int NW = 16;
    localparam int SW = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b1;
    logic           start = 1'b0;
    logic [7:0]     cfg_in = 8'h00;
    logic [NW-1:0]  avail_mask = '1;
    logic [NW*SW-1:0] samples_flat;
    logic           ser_clk, ser_data, ser_sel, done;

    int n_checks = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    snap_stream_tx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start        (start),
        .cfg_in       (cfg_in),
        .avail_mask   (avail_mask),
        .samples_flat (samples_flat),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .ser_sel      (ser_sel),
        .done         (done)
    );

    // Stimulus table: {cfg, avail_mask}.
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        24'h00_FFFF,  // all words, fast, continuous
        24'h01_FFFF,  // slow clock
        24'h08_FFFF,  // first seven words
        24'h10_7F7F,  // power words, some unavailable
        24'h18_FFFF,  // reserved subset behaves as all
        24'h0C_FFFF,  // gaps, 32-bit packages, first seven
        24'h17_FFFF,  // gaps, 8-bit packages, power words, slow
        24'h22_F0F0,  // active-high select, small pkg flag without gaps
        24'hCE_FFFF,  // upper bits set, gaps, 8-bit, first seven
        24'h24_0F0F   // active-high select, gaps, 32-bit, all words
    };

    function automatic logic [SW-1:0] sample_val(input int k);
        if (k % 2 == 1) return 24'hC00000 | 24'(k * 24'h000111);
        else            return 24'(24'h012345 + k * 24'h020304);
    endfunction

    function automatic int exp_count(input logic [7:0] c);
        if (c[4:3] == 2'b01) return 7;
        if (c[4:3] == 2'b10) return 9;
        return 16;
    endfunction

    function automatic logic [31:0] exp_word(input int slot, input logic [7:0] c,
                                             input logic [NW-1:0] m);
        int idx;
        logic [SW-1:0] s;
        idx = (c[4:3] == 2'b10) ? 7 + slot : slot;
        if (!m[idx]) return 32'h0;
        s = sample_val(idx);
        return {{8{s[SW-1]}}, s};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Run one burst and check it as a receiver would; optionally disturb it.
    task automatic run_burst(input logic [7:0] c, input logic [NW-1:0] m, input bit disturb);
        logic [31:0] rxw [NW];
        int nb = 0, gaps = 0, gap_bad = 0, cur_gap = 0, sel_bad = 0, sp_bad = 0;
        int cyc = 0, last_rise = -1, div, pkg, nw, word_bad = 0, first_bad = -1;
        bit had_gap = 0, seen_done = 0, dist_done = 0, prev_clk = 1'b1;
        div = c[0] ? 4 : 2;
        pkg = c[1] ? 8 : 32;
        nw  = exp_count(c);
        for (int i = 0; i < NW; i++) rxw[i] = '0;
        @(negedge clk);
        cfg_in = c;
        avail_mask = m;
        @(negedge clk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 8000) begin
            if (done) begin
                seen_done = 1;
            end else begin
                if (ser_clk && !prev_clk) begin
                    if (ser_sel != c[5]) sel_bad++;
                    if (last_rise >= 0 && (cyc - last_rise) != (had_gap ? 8 * div : div)) sp_bad++;
                    last_rise = cyc;
                    had_gap = 0;
                    if (nb < NW * 32) rxw[nb / 32] = {rxw[nb / 32][30:0], ser_data};
                    nb++;
                end
                if (ser_sel != c[5]) begin
                    cur_gap++;
                    if (!ser_clk) gap_bad++;
                end else if (cur_gap > 0) begin
                    gaps++;
                    if (cur_gap != 7 * div) gap_bad++;
                    cur_gap = 0;
                    had_gap = 1;
                end
                prev_clk = ser_clk;
                @(negedge clk);
                cyc++;
                start = 1'b0;
                if (disturb && !dist_done && nb == 40) begin
                    start = 1'b1;       // R10 restart attempt mid-burst
                    cfg_in = c ^ 8'h27; // R10 reconfigure mid-burst
                    dist_done = 1;
                end
            end
        end
        chk(seen_done, "R12", "done seen", seen_done, 1);
        chk(nb == nw * 32, "R2", "bit count", nb, nw * 32);
        for (int w = 0; w < nw; w++) begin
            if (rxw[w] !== exp_word(w, c, m)) begin
                word_bad++;
                if (first_bad < 0) first_bad = w;
            end
        end
        if (first_bad >= 0)
            chk(0, "R3/R4", $sformatf("word %0d cfg %0h", first_bad, c),
                rxw[first_bad], exp_word(first_bad, c, m));
        else
            chk(1, "R3", "words", 0, 0);
        chk(gaps == (c[2] ? (nw * 32 / pkg) - 1 : 0), "R6", "gap count", gaps,
            c[2] ? (nw * 32 / pkg) - 1 : 0);
        chk(gap_bad == 0, "R7", "gap length or clock in gap", gap_bad, 0);
        chk(sel_bad == 0 && sp_bad == 0, "R5", "bit spacing / select at sample",
            sp_bad + sel_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R12", "done width", done, 0);
        cfg_in = c;
        if (!disturb)
            chk(ser_sel == !c[5] && ser_data && ser_clk, "R8", "idle select level",
                {ser_sel, ser_data, ser_clk}, {!c[5], 2'b11});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        bit idle_ok;
        bit no_done;
        for (int k = 0; k < NW; k++) samples_flat[k*SW +: SW] = sample_val(k);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ser_data && ser_clk && ser_sel && !done, "R1", "lines in reset",
            {ser_data, ser_clk, ser_sel, done}, 4'b1110);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ser_data && ser_clk && ser_sel && !done, "R1", "lines after reset",
            {ser_data, ser_clk, ser_sel, done}, 4'b1110);

        // Table walk: R2..R9, R12
        for (int v = 0; v < NV; v++) begin
            run_burst(VEC[v][23:16], VEC[v][15:0], 1'b0);
        end

        // R10: restart and reconfigure during a burst have no effect
        run_burst(8'h0E, 16'hFFFF, 1'b1);

        // R11: start ignored while disabled
        enable = 1'b0;
        cfg_in = 8'h00;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idle_ok = 1;
        no_done = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ser_clk || !ser_sel || !ser_data) idle_ok = 0;
            if (done) no_done = 0;
        end
        chk(idle_ok && no_done, "R11", "disabled start", {idle_ok, no_done}, 2'b11);

        // R11: abort mid-burst
        enable = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        chk(!ser_sel, "R11", "burst running before abort", ser_sel, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(ser_clk && ser_data && ser_sel, "R11", "lines idle after abort",
            {ser_clk, ser_data, ser_sel}, 3'b111);
        no_done = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done || !ser_clk) no_done = 0;
        end
        chk(no_done, "R11", "no done after abort", no_done, 1);
        enable = 1'b1;

        // Normal operation resumes after an abort
        run_burst(8'h09, 16'hFFFF, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule